// File: doc/BRIEF.md
# Per-Channel Output Power-Mode Controller

This block keeps the power state of eight analog output channels. Each channel is either driving (active) or in one of three shutdown flavours: output floating, output pulled hard to ground, or output pulled gently to ground. A 16-bit command word arrives with a one-cycle valid strobe. Its top four bits form a control code. The power code carries an eight-bit channel mask and a two-bit mode selector. The mode is written into every masked channel, and every unmasked channel keeps its mode.

For every channel the block drives four one-hot status lines: enable, high-Z, strong pull-down and weak pull-down. It also drives a ready flag. When a channel is brought out of shutdown, its ready flag stays low for a programmable number of clocks, which models the output amplifier's wake-up time. Three events force every channel into the weak pull-down shutdown state: a synchronous reset, a global software reset command, and a hardware clear input. That state is therefore the safe default for the outputs.

Top module: `chan_power_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, every channel goes to weak pull-down shutdown with ready low, which is visible after that edge.
- R2: A valid word with bits 15:12 = 4'b1111 is a power command. Bits 11:4 are the mask, with channel k (k = 1..8, output index k-1) at bit k+3. Selector bits 3:2 = 2'b11 make each masked channel active (enable high) after the sampling edge.
- R3: Selector 2'b01 puts each masked channel in high-impedance shutdown (hiz high).
- R4: Selector 2'b10 puts each masked channel in strong pull-down shutdown (pd_strong high).
- R5: Selector 2'b00 puts each masked channel in weak pull-down shutdown (pd_weak high).
- R6: A channel whose mask bit is 0 keeps its mode and its wake-up count. Word bits 1:0 have no effect.
- R7: A valid word with bits 15:12 = 4'b0001 puts all channels in weak pull-down shutdown. A valid word with any control code other than 4'b0001 or 4'b1111 changes nothing.
- R8: `clear` high at a clock edge puts all channels in weak pull-down shutdown. It takes priority over a command sampled at the same edge.
- R9: When a channel changes from any shutdown mode to active, its ready flag stays low and rises exactly WAKE_CYCLES clocks after the edge that sampled the command.
- R10: Ready is low in every shutdown mode. A shutdown during the wake-up count cancels the count. A power-up command to a channel that is already active does not restart its count.
- R11: For each channel, exactly one of enable, hiz, pd_strong and pd_weak is high at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear | input | 1 | Synchronous hardware clear, active high |
| cmd_valid | input | 1 | Command word strobe, one cycle per word |
| cmd_word | input | 16 | Command word |
| ch_enable | output | 8 | Channel output driving |
| ch_hiz | output | 8 | Channel shut down, output floating |
| ch_pd_strong | output | 8 | Channel shut down, strong pull-down |
| ch_pd_weak | output | 8 | Channel shut down, weak pull-down |
| ch_ready | output | 8 | Channel active and wake-up time elapsed |

## Verification
The stimulus uses each selector with masks that are sparse, dense and empty. An empty mask separates a proper per-bit update from a write to all channels. Varying bits 1:0 separates ignored bits from bits that are wrongly decoded. Repeated power-up commands arrive in the middle of a wake-up count, and shutdowns arrive during one. These cases tell apart a counter that restarts on every write, one that restarts only on a real transition, and one that survives a shutdown. Clear arrives together with a power command, and a stray control code is sent, so that priority and code decoding are checked. A behavioural model is compared with every output on every clock.

// File: rtl/chan_pwr_pkg.sv
// Shared definitions for the per-channel power-mode controller.
// Assumes a 16-bit command word with the control code in the top nibble.
package chan_pwr_pkg;

    localparam int WORD_W   = 16;
    localparam int CTRL_HI  = 15;
    localparam int CTRL_LO  = 12;
    localparam int MASK_LO  = 4;
    localparam int SEL_HI   = 3;
    localparam int SEL_LO   = 2;

    localparam logic [3:0] CODE_POWER = 4'b1111;
    localparam logic [3:0] CODE_RESET = 4'b0001;

    // Mode encoding equals the selector value of a power command.
    typedef enum logic [1:0] {
        MODE_WEAK   = 2'b00,
        MODE_HIZ    = 2'b01,
        MODE_STRONG = 2'b10,
        MODE_ACTIVE = 2'b11
    } pwr_mode_e;

endpackage

// File: rtl/chan_pwr_cmd_decode.sv
// Command decoder: classifies one command word into a global reset
// request or a masked power update. Assumes cmd_valid is a one-cycle strobe.
module chan_pwr_cmd_decode
    import chan_pwr_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [WORD_W-1:0] cmd_word,
    output logic              soft_rst,
    output logic              pwr_upd,
    output logic [NUM_CH-1:0] upd_mask,
    output pwr_mode_e         upd_mode
);

    logic [3:0] ctrl_code;
    logic [1:0] spare_bits;

    // Split the word into its fields; bits 1:0 carry no meaning.
    always_comb begin
        ctrl_code  = cmd_word[CTRL_HI:CTRL_LO];
        spare_bits = cmd_word[1:0];
        upd_mask   = cmd_word[MASK_LO +: NUM_CH];
        upd_mode   = pwr_mode_e'(cmd_word[SEL_HI:SEL_LO]);
        soft_rst   = cmd_valid && (ctrl_code == CODE_RESET);
        pwr_upd    = cmd_valid && (ctrl_code == CODE_POWER);
    end

    // R7: a single word never requests both a global reset and an update.
    assert_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(soft_rst && pwr_upd));

    // R6: the ignored low bits never gate the update strobe.
    assert_spare_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && ctrl_code == CODE_POWER && spare_bits != 2'b00) |-> pwr_upd);

endmodule

// File: rtl/chan_pwr_status.sv
// Status decoder: converts a channel's 2-bit mode into four one-hot lines.
// Assumes the mode input always holds a legal encoding, since all four codes are used.
module chan_pwr_status
    import chan_pwr_pkg::*;
(
    input  pwr_mode_e mode,
    output logic      st_enable,
    output logic      st_hiz,
    output logic      st_strong,
    output logic      st_weak
);

    // One line per mode; exactly one is high.
    always_comb begin
        st_enable = 1'b0;
        st_hiz    = 1'b0;
        st_strong = 1'b0;
        st_weak   = 1'b0;
        case (mode)
            MODE_ACTIVE: st_enable = 1'b1;
            MODE_HIZ:    st_hiz    = 1'b1;
            MODE_STRONG: st_strong = 1'b1;
            default:     st_weak   = 1'b1;
        endcase
    end

endmodule

// File: rtl/chan_pwr_slot.sv
// One channel: holds the mode register and the wake-up counter, and drives
// the status and ready outputs. Assumes force_def takes priority over load.
module chan_pwr_slot
    import chan_pwr_pkg::*;
#(
    parameter int WAKE_CYCLES = 6000,
    localparam int CNT_W = $clog2(WAKE_CYCLES + 2)
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      force_def,
    input  logic      load,
    input  pwr_mode_e new_mode,
    output logic      en_o,
    output logic      hiz_o,
    output logic      strong_o,
    output logic      weak_o,
    output logic      ready_o
);

    localparam logic [CNT_W-1:0] WAKE_LD = CNT_W'(WAKE_CYCLES);

    pwr_mode_e        mode_q;
    logic [CNT_W-1:0] wake_cnt;
    logic             leaving_sd;

    // Detect a real transition from shutdown to active.
    always_comb begin
        leaving_sd = load && (new_mode == MODE_ACTIVE) && (mode_q != MODE_ACTIVE);
    end

    // Mode register with forced default on reset or clear.
    always_ff @(posedge clk) begin
        if (!rst_n || force_def) begin
            mode_q <= MODE_WEAK;
        end else if (load) begin
            mode_q <= new_mode;
        end
    end

    // Wake-up counter: loaded on leaving shutdown, cleared by shutdown, else counts down.
    always_ff @(posedge clk) begin
        if (!rst_n || force_def) begin
            wake_cnt <= '0;
        end else if (leaving_sd) begin
            wake_cnt <= WAKE_LD;
        end else if (load && new_mode != MODE_ACTIVE) begin
            wake_cnt <= '0;
        end else if (wake_cnt != '0) begin
            wake_cnt <= wake_cnt - 1'b1;
        end
    end

    chan_pwr_status u_status (
        .mode      (mode_q),
        .st_enable (en_o),
        .st_hiz    (hiz_o),
        .st_strong (strong_o),
        .st_weak   (weak_o)
    );

    // Ready only when driving and the count has drained.
    always_comb begin
        ready_o = en_o && (wake_cnt == '0);
    end

    // R6: without load or force, the mode holds.
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !force_def) |=> $stable(mode_q));

    // R8: a forced default always lands in weak pull-down.
    assert_default_R8: assert property (@(posedge clk) disable iff (!rst_n)
        force_def |=> weak_o);

    // R9: the first active cycle after shutdown is never ready.
    assert_wake_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((WAKE_CYCLES > 0) && $rose(en_o)) |-> !ready_o);

    // R10: ready implies the channel is driving.
    assert_ready_active_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> en_o);

    // R11: the four status lines are one-hot.
    assert_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({en_o, hiz_o, strong_o, weak_o}));

endmodule

// File: rtl/chan_power_ctrl.sv
// Top: per-channel output power-mode controller. It decodes command words
// and applies mask-selected mode changes to NUM_CH channel slots.
// Assumes a synchronous active-low reset and synchronous clear.
module chan_power_ctrl
    import chan_pwr_pkg::*;
#(
    parameter int NUM_CH      = 8,
    parameter int WAKE_CYCLES = 6000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              cmd_valid,
    input  logic [WORD_W-1:0] cmd_word,
    output logic [NUM_CH-1:0] ch_enable,
    output logic [NUM_CH-1:0] ch_hiz,
    output logic [NUM_CH-1:0] ch_pd_strong,
    output logic [NUM_CH-1:0] ch_pd_weak,
    output logic [NUM_CH-1:0] ch_ready
);

    logic              soft_rst;
    logic              pwr_upd;
    logic [NUM_CH-1:0] upd_mask;
    pwr_mode_e         upd_mode;
    logic              force_def;

    chan_pwr_cmd_decode #(.NUM_CH(NUM_CH)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_word  (cmd_word),
        .soft_rst  (soft_rst),
        .pwr_upd   (pwr_upd),
        .upd_mask  (upd_mask),
        .upd_mode  (upd_mode)
    );

    // Clear and the software reset share one forced-default path.
    always_comb begin
        force_def = clear || soft_rst;
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        chan_pwr_slot #(.WAKE_CYCLES(WAKE_CYCLES)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .force_def (force_def),
            .load      (pwr_upd && upd_mask[i]),
            .new_mode  (upd_mode),
            .en_o      (ch_enable[i]),
            .hiz_o     (ch_hiz[i]),
            .strong_o  (ch_pd_strong[i]),
            .weak_o    (ch_pd_weak[i]),
            .ready_o   (ch_ready[i])
        );
    end

    // R1: the cycle after reset shows every channel in weak pull-down.
    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (ch_pd_weak == '1 && ch_ready == '0));

endmodule

// File: tb/chan_power_ctrl_test.sv
// Bench: behavioural reference model compared with every output each clock.
module chan_power_ctrl_test;

    localparam int NCH  = 8;
    localparam int WAKE = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [15:0] cmd_word = '0;
    logic [7:0]  ch_enable, ch_hiz, ch_pd_strong, ch_pd_weak, ch_ready;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    string cur_req = "R1";

    int m_mode [NCH];
    int m_cnt  [NCH];

    chan_power_ctrl #(.NUM_CH(NCH), .WAKE_CYCLES(WAKE)) uut (
        .clk(clk), .rst_n(rst_n), .clear(clear), .cmd_valid(cmd_valid),
        .cmd_word(cmd_word), .ch_enable(ch_enable), .ch_hiz(ch_hiz),
        .ch_pd_strong(ch_pd_strong), .ch_pd_weak(ch_pd_weak), .ch_ready(ch_ready)
    );

    always #2 clk = ~clk;

    // Reference model: 0 weak, 1 hiz, 2 strong, 3 active.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n || clear || (cmd_valid && cmd_word[15:12] == 4'h1)) begin
            for (int i = 0; i < NCH; i++) begin m_mode[i] = 0; m_cnt[i] = 0; end
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (cmd_valid && cmd_word[15:12] == 4'hF && cmd_word[4+i]) begin
                    int nm;
                    nm = int'(cmd_word[3:2]);
                    if (nm == 3 && m_mode[i] != 3) m_cnt[i] = WAKE;
                    else if (nm != 3) m_cnt[i] = 0;
                    else if (m_cnt[i] > 0) m_cnt[i]--;
                    m_mode[i] = nm;
                end else if (m_cnt[i] > 0) begin
                    m_cnt[i]--;
                end
            end
        end
    end

    function automatic logic [7:0] exp_vec(int which);
        logic [7:0] v;
        for (int i = 0; i < NCH; i++) begin
            case (which)
                0: v[i] = (m_mode[i] == 3);
                1: v[i] = (m_mode[i] == 1);
                2: v[i] = (m_mode[i] == 2);
                3: v[i] = (m_mode[i] == 0);
                default: v[i] = (m_mode[i] == 3) && (m_cnt[i] == 0);
            endcase
        end
        return v;
    endfunction

    task automatic check(string what, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", cur_req, what, act, exp, $time);
        end
    endtask

    // Compare every output against the model on each falling edge.
    always @(negedge clk) begin
        if (cycles > 0) begin
            check("enable", ch_enable, exp_vec(0));
            check("hiz", ch_hiz, exp_vec(1));
            check("strong", ch_pd_strong, exp_vec(2));
            check("weak", ch_pd_weak, exp_vec(3));
            check("ready", ch_ready, exp_vec(4));
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(logic [15:0] w);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_word  = w;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_word  = '0;
    endtask

    function automatic logic [15:0] pw(logic [1:0] sel, logic [7:0] mask, logic [1:0] lo);
        return {4'hF, mask, sel, lo};
    endfunction

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cur_req = "R1";
        idle(3);
        check("R1 reset weak", ch_pd_weak, 8'hFF);
        rst_n = 1'b1;
        idle(2);

        cur_req = "R2";
        send(pw(2'b11, 8'h0F, 2'b11));
        check("R2 enable ch1-4", ch_enable, 8'h0F);
        check("R9 not ready yet", ch_ready, 8'h00);
        idle(4);

        cur_req = "R10";
        send(pw(2'b11, 8'h01, 2'b00));   // already active: no restart
        idle(WAKE);
        check("R9 ready after wake", ch_ready, 8'h0F);

        cur_req = "R3";
        send(pw(2'b01, 8'h30, 2'b10));
        check("R3 hiz ch5-6", ch_hiz, 8'h30);

        cur_req = "R4";
        send(pw(2'b10, 8'hC0, 2'b01));
        check("R4 strong ch7-8", ch_pd_strong, 8'hC0);

        cur_req = "R5";
        send(pw(2'b00, 8'h03, 2'b11));
        check("R5 weak ch1-2", ch_pd_weak, 8'h03);

        cur_req = "R6";
        send(pw(2'b11, 8'h00, 2'b11));
        check("R6 empty mask", ch_enable, 8'h0C);
        idle(2);

        cur_req = "R9";
        send(pw(2'b11, 8'hF0, 2'b00));
        idle(3);
        cur_req = "R10";
        send(pw(2'b10, 8'h20, 2'b00));   // cancel count on ch6
        send(pw(2'b11, 8'h20, 2'b00));   // restart ch6
        idle(WAKE + 2);
        check("R10 ready set", ch_ready, 8'hFC);

        cur_req = "R7";
        send({4'h5, 8'hFF, 4'hF});
        check("R7 stray code", ch_enable, 8'hFC);
        send({4'h1, 12'h000});
        check("R7 soft reset", ch_pd_weak, 8'hFF);

        cur_req = "R8";
        send(pw(2'b11, 8'hFF, 2'b00));
        idle(3);
        @(negedge clk);
        clear = 1'b1;
        cmd_valid = 1'b1;
        cmd_word = pw(2'b01, 8'hFF, 2'b00);
        @(negedge clk);
        clear = 1'b0;
        cmd_valid = 1'b0;
        check("R8 clear wins", ch_pd_weak, 8'hFF);

        cur_req = "R11";
        send(pw(2'b11, 8'h81, 2'b00));
        send(pw(2'b01, 8'h42, 2'b00));
        send(pw(2'b10, 8'h24, 2'b00));
        check("R11 onehot", ch_enable | ch_hiz | ch_pd_strong | ch_pd_weak, 8'hFF);
        idle(WAKE);

        cur_req = "R1";
        @(negedge clk);
        rst_n = 1'b0;
        idle(2);
        check("R1 reset mid-run", ch_pd_weak, 8'hFF);
        rst_n = 1'b1;
        idle(3);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule